// File: doc/BRIEF.md
# Serial Interrupt Slave Encoder

This block lets a peripheral report a set of active-low interrupt request lines, plus one I/O channel check line, to a host controller. Everything travels over one shared open-drain wire that runs on the bus clock. Every reporting cycle begins with a start pulse. A train of three-clock data frames follows in a fixed order: request 0 up to the last request, and the channel check frame last. A stop pulse ends the cycle, and its width tells every slave how the next cycle will be started.

The slave finds the end of the start pulse by watching for the wire to return high. It does not assume a fixed pulse width. At that point it takes a snapshot of its sources. In the sample clock of each frame whose source is asserted, it pulls the wire low. In the next clock it drives the wire high to speed recovery, and in the turn-around clock it lets go. It measures the stop pulse to learn the mode. In quiet mode the slave may open a cycle by itself when a source has changed: it pulls the idle wire low for one clock and then lets the host stretch the pulse. In continuous mode only the host opens cycles.

The wire is split into a sampled input (`sirq_in`), a drive enable and a drive value. The pad and the host side are not part of this block.

Top module: `sirq_slave`

## Requirements
- R1: When reset is applied, the slave is in continuous mode (`quiet_mode` = 0) and the wire is released (`sirq_oe` = 0), and it stays that way while the wire stays idle.
- R2: A start pulse from the host, 4 to 8 clocks long, is tracked until its end, which is the first clock in which the wire is high again. The slave does not drive the wire during the start pulse, the recovery clock after it, or the turn-around clock that follows. The sample clock of frame 0 is the second clock after the first high clock.
- R3: Frame f (f = 0..15 for `irq_n[f]`, f = 16 for `chk_n`) takes clocks 3f, 3f+1 and 3f+2 counted from the frame 0 sample clock. If its source is asserted (0), the slave drives 0 in clock 3f, drives 1 in clock 3f+1, and releases the wire in clock 3f+2.
- R4: If a frame's source is deasserted (1), the wire stays released for all three clocks of that frame.
- R5: The source values are captured in the first high clock after the start pulse. A change to the sources during the data frames does not alter what the current cycle reports.
- R6: A stop pulse of exactly 2 low clocks sets quiet mode. A stop pulse of 3 low clocks sets continuous mode. Idle high clocks before the pulse are allowed. `quiet_mode` takes the new value in the clock after the first high clock that ends the pulse.
- R7: In quiet mode, when the wire is idle and the sources differ from the last reported set, the slave drives the wire low for exactly one clock, starting one clock after the change. It then releases the wire and tracks the pulse as in R2. It never starts a cycle if nothing has changed.
- R8: In continuous mode the slave never starts a cycle by itself, even if a source changes.
- R9: During the stop frame and the clocks around it, the slave keeps the wire released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_n | input | 16 | Interrupt sources, active low, frame 0 to 15 |
| chk_n | input | 1 | I/O channel check source, active low, last frame |
| sirq_in | input | 1 | Sampled level of the shared wire |
| sirq_oe | output | 1 | Drive enable for the shared wire |
| sirq_out | output | 1 | Value driven when enabled |
| quiet_mode | output | 1 | Learned mode: 1 quiet, 0 continuous |

## Verification
All outputs come from registers that move on the rising edge. The bench acts as the host: on each falling edge it reads the slave's drive for the current clock and sets its own drive for that clock. The frame 0 sample falls two clocks after the first high clock of a start pulse. A self-started pulse appears one clock after a source changes, and the new mode is visible one clock after the stop pulse ends. The bench counts clocks from those anchors and compares on exactly those cycles. Start widths 4 to 8, stop widths 2 and 3, varying idle gaps, and many source patterns are swept, with every frame of every cycle checked.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OWN   = 3'd1,
    ST_START = 3'd2,
    ST_TA    = 3'd3,
    ST_DATA  = 3'd4,
    ST_STOP  = 3'd5,
    ST_TURN  = 3'd6
  } sirq_state_e;

  localparam int unsigned CLKS_PER_FRAME = 3;
  localparam logic [1:0]  PH_SAMPLE      = 2'd0;
  localparam logic [1:0]  PH_RECOVER     = 2'd1;
  localparam logic [1:0]  PH_TURN        = 2'd2;
endpackage

// File: rtl/sirq_src_latch.sv
module sirq_src_latch #(
  parameter int unsigned WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_n,
  input  logic             capture,
  output logic [WIDTH-1:0] snap_n,
  output logic             pending
);
  logic [WIDTH-1:0] snap_q, snap_d;
  logic [WIDTH-1:0] last_q, last_d;

  always_comb begin
    snap_d = snap_q;
    last_d = last_q;
    if (capture) begin
      snap_d = src_n;
      last_d = src_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '1;
      last_q <= '1;
    end else if (capture) begin
      snap_q <= snap_d;
      last_q <= last_d;
    end
  end

  assign snap_n  = snap_q;
  assign pending = (src_n != last_q);

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap_q)); // R5
endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int unsigned NFRAMES = 17,
  localparam int unsigned FW     = $clog2(NFRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line,
  input  logic          quiet,
  input  logic          pending,
  input  logic          stop_done,
  output logic [FW-1:0] frame,
  output logic [1:0]    phase,
  output logic          in_data,
  output logic          own_drive,
  output logic          in_stop,
  output logic          capture
);
  localparam logic [FW-1:0] LAST = FW'(NFRAMES - 1);

  sirq_state_e   state_q, state_d;
  logic [FW-1:0] frame_q, frame_d;
  logic [1:0]    phase_q, phase_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    phase_d = phase_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!line)                 state_d = ST_START;
        else if (quiet && pending) state_d = ST_OWN;
      end
      ST_OWN:   state_d = ST_START;
      ST_START: if (line) state_d = ST_TA;
      ST_TA: begin
        state_d = ST_DATA;
        frame_d = '0;
        phase_d = PH_SAMPLE;
      end
      ST_DATA: begin
        if (phase_q != PH_TURN) begin
          phase_d = phase_q + 2'd1;
        end else begin
          phase_d = PH_SAMPLE;
          if (frame_q == LAST) state_d = ST_STOP;
          else                 frame_d = frame_q + FW'(1);
        end
      end
      ST_STOP: if (stop_done) state_d = ST_TURN;
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (state_q == ST_TA) || (state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      phase_q <= PH_SAMPLE;
    end else if (cnt_en) begin
      frame_q <= frame_d;
      phase_q <= phase_d;
    end
  end

  assign frame     = frame_q;
  assign phase     = phase_q;
  assign in_data   = (state_q == ST_DATA);
  assign own_drive = (state_q == ST_OWN);
  assign in_stop   = (state_q == ST_STOP);
  assign capture   = (state_q == ST_START) && line;

  AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stop) |-> ($past(frame_q) == LAST && $past(phase_q) == PH_TURN)); // R3
endmodule

// File: rtl/sirq_mode.sv
module sirq_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic in_stop,
  output logic stop_done,
  output logic quiet
);
  logic [1:0] cnt_q, cnt_d;
  logic       quiet_q, quiet_d;
  logic       cnt_en;

  assign stop_done = in_stop && line && (cnt_q != 2'd0);
  assign cnt_en    = in_stop;

  always_comb begin
    cnt_d   = cnt_q;
    quiet_d = quiet_q;
    if (in_stop && !line) begin
      cnt_d = (cnt_q == 2'd3) ? 2'd3 : cnt_q + 2'd1;
    end else if (stop_done) begin
      cnt_d   = 2'd0;
      quiet_d = (cnt_q == 2'd2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 2'd0;
      quiet_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      quiet_q <= quiet_d;
    end
  end

  assign quiet = quiet_q;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_done |=> $stable(quiet_q)); // R6
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_n,
  input  logic               chk_n,
  input  logic               sirq_in,
  output logic               sirq_oe,
  output logic               sirq_out,
  output logic               quiet_mode
);
  localparam int unsigned NFRAMES = NUM_IRQ + 1;
  localparam int unsigned FW      = $clog2(NFRAMES);

  logic [1:0]         rst_q;
  logic               rst_n_s;
  logic [NFRAMES-1:0] snap_n;
  logic               pending, capture, stop_done, quiet;
  logic [FW-1:0]      frame;
  logic [1:0]         phase;
  logic               in_data, own_drive, in_stop, sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  sirq_src_latch #(.WIDTH(NFRAMES)) u_src (
    .clk(clk), .rst_n(rst_n_s), .src_n({chk_n, irq_n}),
    .capture(capture), .snap_n(snap_n), .pending(pending)
  );

  sirq_seq #(.NFRAMES(NFRAMES)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .line(sirq_in), .quiet(quiet),
    .pending(pending), .stop_done(stop_done), .frame(frame), .phase(phase),
    .in_data(in_data), .own_drive(own_drive), .in_stop(in_stop),
    .capture(capture)
  );

  sirq_mode u_mode (
    .clk(clk), .rst_n(rst_n_s), .line(sirq_in), .in_stop(in_stop),
    .stop_done(stop_done), .quiet(quiet)
  );

  assign sel_n      = snap_n[frame];
  assign sirq_oe    = own_drive || (in_data && (phase != PH_TURN) && !sel_n);
  assign sirq_out   = in_data && (phase == PH_RECOVER);
  assign quiet_mode = quiet;

  AST_RECOV_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_data && sirq_oe && !sirq_out) |=> (sirq_oe && sirq_out)); // R3
  AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sirq_oe && sirq_out) |=> !sirq_oe); // R3
  AST_OWN_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n_s)
    own_drive |=> !sirq_oe); // R7
  AST_NO_SELF_START_CONT: assert property (@(posedge clk) disable iff (!rst_n_s)
    own_drive |-> $past(quiet_mode)); // R8
endmodule

// File: tb/sirq_slave_test.sv
module sirq_slave_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_n;
  logic        chk_n;
  logic        host_low;
  logic        sirq_oe, sirq_out, quiet_mode;
  wire         line;
  logic        ob_oe, ob_out, ob_q;
  int          checks = 0;
  int          errs   = 0;
  int          cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = ~(host_low | (sirq_oe & ~sirq_out));

  sirq_slave uut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .chk_n(chk_n),
    .sirq_in(line), .sirq_oe(sirq_oe), .sirq_out(sirq_out),
    .quiet_mode(quiet_mode)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errs++;
      $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  task automatic cyc(input logic hl);
    @(negedge clk);
    ob_oe    = sirq_oe;
    ob_out   = sirq_out;
    ob_q     = quiet_mode;
    host_low = hl;
  endtask

  function automatic logic [1:0] drv();
    return {ob_oe, ob_oe & ob_out};
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_src(input logic [16:0] v);
    {chk_n, irq_n} = v;
  endtask

  function automatic logic [16:0] pat(input int k);
    case (k % 4)
      0:       return 17'h00000;
      1:       return ~(17'b1 << (k % 17));
      2:       return 17'h1FFFF;
      default: return 17'h0A5C3 ^ 17'(k * 4951);
    endcase
  endfunction

  // starts at the first high clock after the start pulse
  task automatic run_body(input logic [16:0] p, input bit mid);
    logic [1:0] e;
    cyc(1'b0); chk("R2 recovery clock released", drv(), 2'b00);
    cyc(1'b0); chk("R2 turn-around clock released", drv(), 2'b00);
    for (int f = 0; f < 17; f++) begin
      for (int ph = 0; ph < 3; ph++) begin
        cyc(1'b0);
        if (p[f]) e = 2'b00;
        else      e = (ph == 0) ? 2'b10 : (ph == 1) ? 2'b11 : 2'b00;
        if (mid)       chk("R5 snapshot frame", drv(), e);
        else if (p[f]) chk("R4 deasserted frame", drv(), e);
        else           chk("R3 asserted frame", drv(), e);
        if (mid && f == 5 && ph == 0)  set_src(~p);
        if (mid && f == 10 && ph == 0) set_src(p);
      end
    end
  endtask

  task automatic run_stop(input int idle, input int len, input logic expq);
    for (int i = 0; i < idle; i++) begin
      cyc(1'b0); chk("R9 idle before stop", drv(), 2'b00);
    end
    for (int i = 0; i < len; i++) begin
      cyc(1'b1); chk("R9 stop pulse released", drv(), 2'b00);
    end
    cyc(1'b0); chk("R9 stop recovery released", drv(), 2'b00);
    cyc(1'b0); chk("R9 stop turn-around released", drv(), 2'b00);
    chk("R6 mode after stop", {1'b0, ob_q}, {1'b0, expq});
  endtask

  task automatic host_cycle(input int w, input logic [16:0] p, input bit mid,
                            input int idle, input int len, input logic expq);
    for (int i = 0; i < w; i++) begin
      cyc(1'b1); chk("R2 start pulse released", drv(), 2'b00);
    end
    run_body(p, mid);
    run_stop(idle, len, expq);
  endtask

  task automatic own_cycle(input int h, input logic [16:0] p,
                           input int len, input logic expq);
    cyc(1'b0); chk("R7 no start without change", drv(), 2'b00);
    set_src(p);
    cyc(1'b0); chk("R7 own start drives low", drv(), 2'b10);
    for (int i = 0; i < h; i++) begin
      cyc(1'b1); chk("R7 released after one clock", drv(), 2'b00);
    end
    run_body(p, 1'b0);
    run_stop(1, len, expq);
  endtask

  task automatic cont_idle(input logic [16:0] p);
    set_src(p);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0); chk("R8 no self start in continuous", drv(), 2'b00);
    end
  endtask

  initial begin
    logic [16:0] prev, np;
    rst_n    = 1'b0;
    host_low = 1'b0;
    set_src(17'h1FFFF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0);
      chk("R1 reset released", drv(), 2'b00);
      chk("R1 reset continuous", {1'b0, ob_q}, 2'b00);
    end
    for (int run = 0; run < 10; run++) begin
      cont_idle(pat(run));
      host_cycle(4 + run % 5, pat(run), run == 4, run % 3,
                 (run == 9) ? 2 : 3, run == 9);
    end
    prev = pat(9);
    host_cycle(6, prev, 1'b0, 1, 2, 1'b1);
    for (int run = 0; run < 6; run++) begin
      np = pat(10 + run);
      if (np == prev) np[0] = ~np[0];
      own_cycle(3 + run % 5, np, (run == 5) ? 3 : 2, run != 5);
      prev = np;
    end
    cont_idle(~prev);
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule